// File: doc/BRIEF.md
# Single-Wire Bus Transmit Guard and Receive Conditioner

This block sits between a protocol controller and the analog driver and comparator of a single-wire bus transceiver. On the transmit side, it synchronises the controller's transmit-data line and turns a low level into a request for a dominant bus. A watchdog counts timebase ticks while that request is active. If the request lasts too long, the watchdog cuts the driver request off, so a stuck controller cannot hold the bus dominant. The cut-off is lifted as soon as the transmit line goes high again.

On the receive side, the comparator output is synchronised and passed through a minimum-pulse filter that removes short glitches. Each time the node releases the bus, a blanking window starts, so ringing on the line does not reach the controller. While the window is open, the receive-data output stays recessive. A sleep mode holds the driver request off and the receive output recessive. The lengths of the timeout, the blanking window and the pulse filter are all counted in timebase ticks and are set by parameters.

Top module: `swc_txrx_cond`

## Requirements
- R1: With `mode_i` other than 2'b00, `drv_dom_o` is 1 exactly while the synchronised `txd_i` is 0. Both edges reach `drv_dom_o` two clock cycles after `txd_i` changes.
- R2: If `txd_i` stays low for TO_TICKS tick strobes, `drv_dom_o` falls to 0 and stays 0 for as long as `txd_i` remains low.
- R3: The timeout advances only on clock edges where `tick_i` is 1. With `tick_i` held at 0, a low `txd_i` is driven dominant indefinitely.
- R4: The timeout counter saturates and does not wrap. After a cut-off, the next high level on `txd_i` clears it, and the following low level is again driven for a full TO_TICKS ticks.
- R5: From the cycle in which the synchronised `txd_i` rises, `rxd_o` is held at 1 (recessive) for BLANK_TICKS further tick strobes, whatever the comparator reports.
- R6: A change on `cmp_dom_i` reaches `rxd_o` only after it has held for FILT_TICKS consecutive tick strobes, which takes FILT_TICKS+2 clock cycles with `tick_i` high. Shorter pulses of either polarity are discarded.
- R7: `cmp_dom_i` = 1 means the bus is dominant and gives `rxd_o` = 0. `cmp_dom_i` = 0 gives `rxd_o` = 1.
- R8: With `mode_i` = 2'b00 (sleep), `drv_dom_o` is 0 regardless of `txd_i` and `rxd_o` is 1 regardless of `cmp_dom_i`. Leaving sleep restores both paths in the same cycle.
- R9: After reset, with `txd_i` high and `cmp_dom_i` low, `drv_dom_o` is 0 and `rxd_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase strobe; each cycle it is high counts as one tick |
| mode_i | input | 2 | Operating mode; 2'b00 is sleep, every other value is active |
| txd_i | input | 1 | Transmit data from the controller; low requests dominant |
| cmp_dom_i | input | 1 | Bus comparator output; high means bus dominant |
| drv_dom_o | output | 1 | Request to the bus driver to drive dominant |
| rxd_o | output | 1 | Receive data to the controller; low means bus dominant |

## Verification
The assertions assume that `mode_i` is produced synchronously to `clk`, because it gates both outputs without a synchroniser. They also assume that `tick_i` is a single-cycle strobe. Only `txd_i` and `cmp_dom_i` may change asynchronously. The bench changes every input on the falling clock edge and changes `mode_i` only between tests. It gates `tick_i` only while it checks that the timeout stops counting.

// File: rtl/swc_cond_pkg.sv
package swc_cond_pkg;

   typedef enum logic [1:0] {
      SWC_SLEEP  = 2'b00,
      SWC_FAST   = 2'b01,
      SWC_WAKEHV = 2'b10,
      SWC_NORMAL = 2'b11
   } swc_mode_e;

   // Width of a counter that must hold values 0..limit inclusive.
   function automatic int unsigned cnt_width(input int unsigned limit);
      int unsigned w;
      w = 1;
      while ((1 << w) <= limit) w++;
      return w;
   endfunction

endpackage

// File: rtl/swc_sync.sv
module swc_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("swc_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= RST_VAL;
            else if (s == 0) chain_q[s] <= d_i;
            else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/swc_tx_guard.sv
module swc_tx_guard #(
   parameter int unsigned TO_TICKS = 24,
   localparam int unsigned CW = swc_cond_pkg::cnt_width(TO_TICKS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   input  logic          txd_s_i,
   input  logic          sleep_i,
   output logic          drv_dom_o,
   output logic [CW-1:0] dom_cnt_o
);

   localparam logic [CW-1:0] LAST = CW'(TO_TICKS - 1);
   localparam logic [CW-1:0] SAT  = CW'(TO_TICKS);

   logic [CW-1:0] cnt_q;
   logic          cut_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         cut_q <= 1'b0;
      end else if (txd_s_i) begin
         // Recessive request: clear both the count and any cut-off.
         cnt_q <= '0;
         cut_q <= 1'b0;
      end else if (tick_i && !cut_q) begin
         if (cnt_q == LAST) cut_q <= 1'b1;
         if (cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign drv_dom_o = !txd_s_i && !cut_q && !sleep_i;
   assign dom_cnt_o = cnt_q;

endmodule

// File: rtl/swc_rx_filter.sv
module swc_rx_filter #(
   parameter int unsigned FILT_TICKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic dom_s_i,
   output logic dom_f_o
);

   generate
      if (FILT_TICKS == 0) begin : g_pass
         assign dom_f_o = dom_s_i;
      end else begin : g_filt
         localparam int unsigned FW = swc_cond_pkg::cnt_width(FILT_TICKS);
         localparam logic [FW-1:0] LAST = FW'(FILT_TICKS - 1);
         logic [FW-1:0] run_q;
         logic          state_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q   <= '0;
               state_q <= 1'b0;
            end else if (dom_s_i == state_q) begin
               run_q <= '0;
            end else if (tick_i) begin
               if (run_q == LAST) begin
                  state_q <= dom_s_i;
                  run_q   <= '0;
               end else begin
                  run_q <= run_q + 1'b1;
               end
            end
         end

         assign dom_f_o = state_q;
      end
   endgenerate

endmodule

// File: rtl/swc_rx_blank.sv
module swc_rx_blank #(
   parameter int unsigned BLANK_TICKS = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic rise_i,
   output logic blank_o
);

   generate
      if (BLANK_TICKS == 0) begin : g_none
         assign blank_o = 1'b0;
      end else begin : g_win
         localparam int unsigned BW = swc_cond_pkg::cnt_width(BLANK_TICKS);
         localparam logic [BW-1:0] LOAD = BW'(BLANK_TICKS);
         logic [BW-1:0] left_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) left_q <= '0;
            else if (rise_i) left_q <= LOAD;
            else if (tick_i && left_q != '0) left_q <= left_q - 1'b1;
         end

         // The rising cycle itself is covered before the load lands.
         assign blank_o = rise_i || (left_q != '0);
      end
   endgenerate

endmodule

// File: rtl/swc_txrx_cond.sv
module swc_txrx_cond #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned TO_TICKS    = 24,
   parameter int unsigned BLANK_TICKS = 6,
   parameter int unsigned FILT_TICKS  = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic [1:0] mode_i,
   input  logic       txd_i,
   input  logic       cmp_dom_i,
   output logic       drv_dom_o,
   output logic       rxd_o
);

   import swc_cond_pkg::*;

   localparam int unsigned CW = cnt_width(TO_TICKS);

   generate
      if (TO_TICKS < 1) begin : g_bad_to
         $error("swc_txrx_cond: TO_TICKS must be at least 1");
      end
   endgenerate

   logic          txd_s;
   logic          txd_q;
   logic          txd_rise;
   logic          cmp_s;
   logic          dom_f;
   logic          blank;
   logic          sleep;
   logic [CW-1:0] guard_cnt;

   assign sleep = (swc_mode_e'(mode_i) == SWC_SLEEP);

   swc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_tx (
      .clk(clk), .rst_n(rst_n), .d_i(txd_i), .q_o(txd_s)
   );

   swc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_rx (
      .clk(clk), .rst_n(rst_n), .d_i(cmp_dom_i), .q_o(cmp_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) txd_q <= 1'b1;
      else txd_q <= txd_s;
   end

   assign txd_rise = txd_s && !txd_q;

   swc_tx_guard #(.TO_TICKS(TO_TICKS)) u_guard (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .txd_s_i(txd_s),
      .sleep_i(sleep), .drv_dom_o(drv_dom_o), .dom_cnt_o(guard_cnt)
   );

   swc_rx_filter #(.FILT_TICKS(FILT_TICKS)) u_filt (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .dom_s_i(cmp_s), .dom_f_o(dom_f)
   );

   swc_rx_blank #(.BLANK_TICKS(BLANK_TICKS)) u_blank (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rise_i(txd_rise), .blank_o(blank)
   );

   assign rxd_o = !(dom_f && !blank && !sleep);

endmodule

// File: rtl/swc_txrx_cond_chk.sv
module swc_txrx_cond_chk #(
   parameter int unsigned TO_TICKS = 24,
   localparam int unsigned CW = swc_cond_pkg::cnt_width(TO_TICKS)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tick_i,
   input logic [1:0]    mode_i,
   input logic          drv_dom_o,
   input logic          rxd_o,
   input logic          txd_rise,
   input logic          cmp_s,
   input logic          dom_f,
   input logic [CW-1:0] guard_cnt
);

   // Consecutive ticks seen with the driver request active.
   logic [CW:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= '0;
      else if (!drv_dom_o) run_q <= '0;
      else if (tick_i && run_q != {(CW+1){1'b1}}) run_q <= run_q + 1'b1;
   end

   assert_drive_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= (CW+1)'(TO_TICKS));

   assert_cnt_saturates_R4: assert property (@(posedge clk) disable iff (!rst_n)
      guard_cnt <= CW'(TO_TICKS));

   assert_rise_blanks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      txd_rise |-> rxd_o);

   assert_filter_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dom_f) |-> dom_f == $past(cmp_s));

   assert_sleep_recessive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'b00) |-> (rxd_o && !drv_dom_o));

endmodule

bind swc_txrx_cond swc_txrx_cond_chk #(.TO_TICKS(TO_TICKS)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .mode_i(mode_i),
   .drv_dom_o(drv_dom_o), .rxd_o(rxd_o), .txd_rise(txd_rise),
   .cmp_s(cmp_s), .dom_f(dom_f), .guard_cnt(guard_cnt)
);

// File: tb/swc_txrx_cond_tb.sv
`timescale 1ns/1ps
module swc_txrx_cond_tb;

   localparam int TO = 24;
   localparam int BL = 6;
   localparam int FL = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b1;
   logic [1:0] mode = 2'b11;
   logic       txd = 1'b1;
   logic       cmp = 1'b0;
   logic       drv;
   logic       rxd;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   swc_txrx_cond #(.SYNC_STAGES(2), .TO_TICKS(TO), .BLANK_TICKS(BL), .FILT_TICKS(FL)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .mode_i(mode),
      .txd_i(txd), .cmp_dom_i(cmp), .drv_dom_o(drv), .rxd_o(rxd)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      step(3);
      check("R9 drv after reset", drv, 1'b0);
      check("R9 rxd after reset", rxd, 1'b1);
      rst_n = 1'b1;
      step(4);
      check("R9 drv idle", drv, 1'b0);
      check("R9 rxd idle", rxd, 1'b1);
   endtask

   task automatic t_basic_drive;
      txd = 1'b0;
      step(1); check("R1 drv still recessive", drv, 1'b0);
      step(1); check("R1 drv dominant", drv, 1'b1);
      txd = 1'b1;
      step(1); check("R1 drv held one cycle", drv, 1'b1);
      step(1); check("R1 drv released", drv, 1'b0);
      step(BL + 4);
   endtask

   task automatic t_timeout;
      txd = 1'b0;
      step(TO + 1); check("R2 drv before timeout", drv, 1'b1);
      step(1);      check("R2 drv cut at timeout", drv, 1'b0);
      step(3 * TO); check("R4 cut held while low", drv, 1'b0);
      txd = 1'b1;
      step(2);      check("R4 drv recessive on high", drv, 1'b0);
      txd = 1'b0;
      step(2);      check("R4 drv resumes", drv, 1'b1);
      step(TO - 1); check("R4 full window again", drv, 1'b1);
      step(1);      check("R4 second timeout", drv, 1'b0);
      txd = 1'b1;
      step(BL + 4);
   endtask

   task automatic t_tick_gate;
      tick = 1'b0;
      txd = 1'b0;
      step(3 * TO); check("R3 no ticks no timeout", drv, 1'b1);
      tick = 1'b1;
      step(TO - 1); check("R3 counts after ticks resume", drv, 1'b1);
      step(1);      check("R3 timeout after TO ticks", drv, 1'b0);
      txd = 1'b1;
      step(BL + 4);
   endtask

   task automatic t_polarity;
      cmp = 1'b1;
      step(FL + 3); check("R7 dominant gives rxd low", rxd, 1'b0);
      cmp = 1'b0;
      step(FL + 3); check("R7 recessive gives rxd high", rxd, 1'b1);
   endtask

   task automatic t_filter;
      bit seen;
      cmp = 1'b1;
      step(FL - 1);
      cmp = 1'b0;
      seen = 1'b0;
      for (int i = 0; i < FL + 6; i++) begin
         step(1);
         if (rxd !== 1'b1) seen = 1'b1;
      end
      check("R6 short dominant pulse dropped", seen, 1'b0);
      cmp = 1'b1;
      step(FL + 1); check("R6 not yet accepted", rxd, 1'b1);
      step(1);      check("R6 full pulse accepted", rxd, 1'b0);
      step(2);
      cmp = 1'b0;
      step(FL - 1);
      cmp = 1'b1;
      seen = 1'b0;
      for (int i = 0; i < FL + 6; i++) begin
         step(1);
         if (rxd !== 1'b0) seen = 1'b1;
      end
      check("R6 short recessive gap dropped", seen, 1'b0);
      cmp = 1'b0;
      step(FL + 4);
   endtask

   task automatic t_blank;
      cmp = 1'b1;
      step(FL + 3); check("R5 rxd dominant before release", rxd, 1'b0);
      txd = 1'b0;
      step(4);
      txd = 1'b1;
      step(1);      check("R5 not blanked before sync", rxd, 1'b0);
      step(1);      check("R5 blanked on rise", rxd, 1'b1);
      step(BL);     check("R5 blanked at window end", rxd, 1'b1);
      step(1);      check("R5 window closed", rxd, 1'b0);
      cmp = 1'b0;
      step(FL + 4);
   endtask

   task automatic t_sleep;
      bit bad_d, bad_r;
      mode = 2'b00;
      cmp = 1'b1;
      txd = 1'b0;
      bad_d = 1'b0; bad_r = 1'b0;
      for (int i = 0; i < 8; i++) begin
         step(1);
         if (drv !== 1'b0) bad_d = 1'b1;
         if (rxd !== 1'b1) bad_r = 1'b1;
      end
      check("R8 sleep blocks drive", bad_d, 1'b0);
      check("R8 sleep forces rxd high", bad_r, 1'b0);
      mode = 2'b11;
      #1;
      check("R8 drive restored on wake", drv, 1'b1);
      check("R8 rxd restored on wake", rxd, 1'b0);
      txd = 1'b1;
      cmp = 1'b0;
      step(BL + FL + 6);
   endtask

   initial begin
      t_reset();
      t_basic_drive();
      t_timeout();
      t_tick_gate();
      t_polarity();
      t_filter();
      t_blank();
      t_sleep();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int c = 0; c < 100000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule